// File: doc/BRIEF.md
# Shared-Memory Ring Buffer Accessor

This block lets a host-side controller pass single bytes through a circular buffer that sits in the memory of a separate target CPU. Each buffer keeps three control bytes just below its first data slot: the size mask, the producer (write) index and the consumer (read) index. The accessor copies those three bytes into local registers when it is initialised. After that it answers five commands: initialise, test empty, test full, take a byte and store a byte. Each command arrives on a valid/ready command port.

Every command that touches target memory first raises a bus request and waits for the grant. It then performs its reads and writes through a simple valid/ready memory port, and it finishes by dropping the request and waiting for the grant to fall. On every access the block re-reads the index that the other side of the buffer owns, so it never works from a stale copy of that index. When a take finds the buffer empty, or a store finds it full, the block gives the bus back and tries again until the condition clears. A base address of zero marks the buffer as unconfigured. In that state the block answers without using the bus.

Top module: `shm_ring_port`

## Requirements
- R1: After reset, cmd_ready is 1, while bus_req, mem_valid and rsp_valid are 0, and the buffer is unconfigured (base zero).
- R2: cmd_op encodes 0 = initialise, 1 = test empty, 2 = test full, 3 = take, 4 = store. Codes 5 to 7 are answered with rsp_err = 1 and make no memory access.
- R3: Initialise with a nonzero cmd_addr records it as the base. Within one bus tenure it then makes three reads, in this order: the mask at base-3, the producer index at base-2 and the consumer index at base-1. It answers with rsp_err = 0.
- R4: Test empty reads the producer index at base-2 and returns rsp_flag = 1 exactly when that byte equals the locally held consumer index.
- R5: Test full reads the consumer index at base-1 and returns rsp_flag = 1 exactly when (local producer index + 1) AND mask equals that byte.
- R6: Take reads the byte at base + consumer index and returns it on rsp_data. It then sets the consumer index to (index + 1) AND mask and writes the new value to base-1.
- R7: Store writes cmd_data to base + producer index. It then sets the producer index to (index + 1) AND mask and writes the new value to base-2.
- R8: A take on an empty buffer, or a store on a full one, gives no response. Instead it drops bus_req, waits for the grant to fall and requests again, repeating until the condition clears. It then completes as in R6 or R7.
- R9: mem_valid is high only while both bus_req and bus_grant are high. cmd_ready is never high while bus_req is high, and a memory command is answered only after bus_grant has fallen.
- R10: While the base is zero, test empty and test full answer rsp_flag = 1 with rsp_err = 0, and take and store answer rsp_err = 1. Initialise with cmd_addr zero answers rsp_err = 0. None of these raises bus_req.
- R11: All memory addresses are formed modulo 2^AW, so a base of 1 reads its mask at 2^AW - 2 and its consumer index at address 0.
- R12: A memory command that is not accepted keeps mem_valid, mem_addr and mem_we unchanged until mem_ready. Results stay correct when mem_ready is withheld.
- R13: rsp_valid is a one-cycle pulse that occurs only while cmd_ready is high, and a new command can be accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command taken this cycle if valid |
| cmd_op | input | 3 | Operation code (see R2) |
| cmd_addr | input | AW | Buffer base for initialise |
| cmd_data | input | DW | Byte to store |
| rsp_valid | output | 1 | Response pulse |
| rsp_flag | output | 1 | Result of test empty / test full |
| rsp_err | output | 1 | Unconfigured buffer or unknown code |
| rsp_data | output | DW | Byte returned by take |
| bus_req | output | 1 | Bus request to the target's bus controller |
| bus_grant | input | 1 | Bus granted |
| mem_valid | output | 1 | Memory access command |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Target memory address |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | DW | Read data, valid with mem_ready |

## Verification
A response pulse and the acceptance of the next command can fall in the same cycle, because the block returns to idle at the same edge that raises rsp_valid. The bench provokes this by driving each new command as soon as it sees a response, so the command is taken in the response cycle. It runs whole sequences of initialise, store, take and tests this way, including the zero-latency answers of the unconfigured state. It judges the result by checking that cmd_ready is high in every response cycle, that no response is lost or duplicated, and that the indices written back to the bench's memory model match the values computed in the bench.

// File: rtl/shm_ring_pkg.sv
package shm_ring_pkg;

    localparam int unsigned RING_AW  = 19;
    localparam int unsigned RING_DW  = 8;
    localparam int unsigned RING_OPW = 3;

    typedef enum logic [RING_OPW-1:0] {
        OP_INIT  = 3'd0,
        OP_EMPTY = 3'd1,
        OP_FULL  = 3'd2,
        OP_GET   = 3'd3,
        OP_PUT   = 3'd4
    } ring_op_e;

    typedef enum logic [2:0] {
        AS_MASK,
        AS_PROD,
        AS_CONS,
        AS_SLOT_CONS,
        AS_SLOT_PROD
    } addr_sel_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACQ,
        ST_LD_MASK,
        ST_LD_PROD,
        ST_LD_CONS,
        ST_PEEK,
        ST_XFER,
        ST_WBACK,
        ST_REL
    } seq_state_e;

    function automatic logic op_known(input logic [RING_OPW-1:0] code);
        return code <= 3'd4;
    endfunction

    function automatic logic op_is_query(input logic [RING_OPW-1:0] code);
        return (code == 3'd1) || (code == 3'd2);
    endfunction

endpackage

// File: rtl/shm_ring_desc.sv
module shm_ring_desc #(
    parameter int unsigned AW = 19,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_base,
    input  logic [AW-1:0] base_in,
    input  logic          ld_mask,
    input  logic          ld_prod,
    input  logic          ld_cons,
    input  logic [DW-1:0] ld_val,
    input  logic          adv_prod,
    input  logic          adv_cons,
    output logic [AW-1:0] base,
    output logic [DW-1:0] mask,
    output logic [DW-1:0] prod_idx,
    output logic [DW-1:0] cons_idx,
    output logic [DW-1:0] nxt_prod,
    output logic [DW-1:0] nxt_cons,
    output logic          base_zero
);

    localparam logic [DW-1:0] ONE = DW'(1);

    always_comb begin
        nxt_prod  = (prod_idx + ONE) & mask;
        nxt_cons  = (cons_idx + ONE) & mask;
        base_zero = (base == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base     <= '0;
            mask     <= '0;
            prod_idx <= '0;
            cons_idx <= '0;
        end else begin
            if (ld_base) base <= base_in;
            if (ld_mask) mask <= ld_val;
            if (ld_prod)       prod_idx <= ld_val;
            else if (adv_prod) prod_idx <= nxt_prod;
            if (ld_cons)       cons_idx <= ld_val;
            else if (adv_cons) cons_idx <= nxt_cons;
        end
    end

endmodule

// File: rtl/shm_ring_agen.sv
module shm_ring_agen
    import shm_ring_pkg::*;
#(
    parameter int unsigned AW = 19,
    parameter int unsigned DW = 8
) (
    input  logic [AW-1:0] base,
    input  addr_sel_e     sel,
    input  logic [DW-1:0] prod_idx,
    input  logic [DW-1:0] cons_idx,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] OFS_MASK = AW'(3);
    localparam logic [AW-1:0] OFS_PROD = AW'(2);
    localparam logic [AW-1:0] OFS_CONS = AW'(1);

    always_comb begin
        unique case (sel)
            AS_MASK:      addr = base - OFS_MASK;
            AS_PROD:      addr = base - OFS_PROD;
            AS_CONS:      addr = base - OFS_CONS;
            AS_SLOT_CONS: addr = base + AW'(cons_idx);
            AS_SLOT_PROD: addr = base + AW'(prod_idx);
            default:      addr = base;
        endcase
    end

endmodule

// File: rtl/shm_ring_seq.sv
module shm_ring_seq
    import shm_ring_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [RING_OPW-1:0] cmd_op,
    input  logic                cmd_addr_zero,
    input  logic [DW-1:0]       cmd_data,
    input  logic                base_zero,
    output logic                rsp_valid,
    output logic                rsp_flag,
    output logic                rsp_err,
    output logic [DW-1:0]       rsp_data,
    output logic                bus_req,
    input  logic                bus_grant,
    output logic                mem_valid,
    output logic                mem_we,
    output logic [DW-1:0]       mem_wdata,
    output addr_sel_e           addr_sel,
    input  logic                mem_ready,
    input  logic [DW-1:0]       mem_rdata,
    input  logic [DW-1:0]       cons_idx,
    input  logic [DW-1:0]       nxt_prod,
    input  logic [DW-1:0]       nxt_cons,
    output logic                ld_base,
    output logic                ld_mask,
    output logic                ld_prod,
    output logic                ld_cons,
    output logic                adv_prod,
    output logic                adv_cons
);

    seq_state_e    state;
    ring_op_e      op_q;
    logic [DW-1:0] data_q;
    logic [DW-1:0] rdat_q;
    logic          flag_q;
    logic          blocked_q;
    logic          acc;
    logic          on_cons;
    logic          cons_equal;
    logic          prod_hits;

    always_comb begin
        on_cons    = (op_q == OP_GET) || (op_q == OP_EMPTY);
        cmd_ready  = (state == ST_IDLE);
        bus_req    = (state != ST_IDLE) && (state != ST_REL);
        mem_valid  = (state == ST_LD_MASK) || (state == ST_LD_PROD) ||
                     (state == ST_LD_CONS) || (state == ST_PEEK) ||
                     (state == ST_XFER) || (state == ST_WBACK);
        acc        = mem_valid && mem_ready;
        cons_equal = (mem_rdata == cons_idx);
        prod_hits  = (mem_rdata == nxt_prod);

        mem_we    = 1'b0;
        mem_wdata = '0;
        addr_sel  = AS_MASK;
        unique case (state)
            ST_LD_MASK: addr_sel = AS_MASK;
            ST_LD_PROD: addr_sel = AS_PROD;
            ST_LD_CONS: addr_sel = AS_CONS;
            ST_PEEK:    addr_sel = on_cons ? AS_PROD : AS_CONS;
            ST_XFER: begin
                addr_sel  = (op_q == OP_GET) ? AS_SLOT_CONS : AS_SLOT_PROD;
                mem_we    = (op_q == OP_PUT);
                mem_wdata = data_q;
            end
            ST_WBACK: begin
                addr_sel  = (op_q == OP_GET) ? AS_CONS : AS_PROD;
                mem_we    = 1'b1;
                mem_wdata = (op_q == OP_GET) ? nxt_cons : nxt_prod;
            end
            default: addr_sel = AS_MASK;
        endcase

        ld_base  = (state == ST_IDLE) && cmd_valid && (cmd_op == OP_INIT);
        ld_mask  = acc && (state == ST_LD_MASK);
        ld_prod  = acc && (state == ST_LD_PROD);
        ld_cons  = acc && (state == ST_LD_CONS);
        adv_cons = acc && (state == ST_WBACK) && (op_q == OP_GET);
        adv_prod = acc && (state == ST_WBACK) && (op_q == OP_PUT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            op_q      <= OP_INIT;
            data_q    <= '0;
            rdat_q    <= '0;
            flag_q    <= 1'b0;
            blocked_q <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_flag  <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        data_q    <= cmd_data;
                        rdat_q    <= '0;
                        flag_q    <= 1'b0;
                        blocked_q <= 1'b0;
                        if (!op_known(cmd_op)) begin
                            rsp_valid <= 1'b1;
                            rsp_flag  <= 1'b0;
                            rsp_err   <= 1'b1;
                            rsp_data  <= '0;
                        end else begin
                            op_q <= ring_op_e'(cmd_op);
                            if (cmd_op == OP_INIT) begin
                                if (cmd_addr_zero) begin
                                    rsp_valid <= 1'b1;
                                    rsp_flag  <= 1'b0;
                                    rsp_err   <= 1'b0;
                                    rsp_data  <= '0;
                                end else begin
                                    state <= ST_ACQ;
                                end
                            end else if (base_zero) begin
                                rsp_valid <= 1'b1;
                                rsp_flag  <= op_is_query(cmd_op);
                                rsp_err   <= !op_is_query(cmd_op);
                                rsp_data  <= '0;
                            end else begin
                                state <= ST_ACQ;
                            end
                        end
                    end
                end
                ST_ACQ: begin
                    if (bus_grant) state <= (op_q == OP_INIT) ? ST_LD_MASK : ST_PEEK;
                end
                ST_LD_MASK: if (acc) state <= ST_LD_PROD;
                ST_LD_PROD: if (acc) state <= ST_LD_CONS;
                ST_LD_CONS: if (acc) state <= ST_REL;
                ST_PEEK: begin
                    if (acc) begin
                        unique case (op_q)
                            OP_EMPTY: begin
                                flag_q <= cons_equal;
                                state  <= ST_REL;
                            end
                            OP_FULL: begin
                                flag_q <= prod_hits;
                                state  <= ST_REL;
                            end
                            OP_GET: begin
                                if (cons_equal) begin
                                    blocked_q <= 1'b1;
                                    state     <= ST_REL;
                                end else begin
                                    state <= ST_XFER;
                                end
                            end
                            default: begin
                                if (prod_hits) begin
                                    blocked_q <= 1'b1;
                                    state     <= ST_REL;
                                end else begin
                                    state <= ST_XFER;
                                end
                            end
                        endcase
                    end
                end
                ST_XFER: begin
                    if (acc) begin
                        if (op_q == OP_GET) rdat_q <= mem_rdata;
                        state <= ST_WBACK;
                    end
                end
                ST_WBACK: if (acc) state <= ST_REL;
                ST_REL: begin
                    if (!bus_grant) begin
                        if (blocked_q) begin
                            blocked_q <= 1'b0;
                            state     <= ST_ACQ;
                        end else begin
                            state     <= ST_IDLE;
                            rsp_valid <= 1'b1;
                            rsp_flag  <= flag_q;
                            rsp_err   <= 1'b0;
                            rsp_data  <= (op_q == OP_GET) ? rdat_q : '0;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/shm_ring_port.sv
module shm_ring_port
    import shm_ring_pkg::*;
#(
    parameter int unsigned AW = RING_AW,
    parameter int unsigned DW = RING_DW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [RING_OPW-1:0] cmd_op,
    input  logic [AW-1:0]       cmd_addr,
    input  logic [DW-1:0]       cmd_data,
    output logic                rsp_valid,
    output logic                rsp_flag,
    output logic                rsp_err,
    output logic [DW-1:0]       rsp_data,
    output logic                bus_req,
    input  logic                bus_grant,
    output logic                mem_valid,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_wdata,
    input  logic                mem_ready,
    input  logic [DW-1:0]       mem_rdata
);

    logic [AW-1:0] base;
    logic [DW-1:0] mask;
    logic [DW-1:0] prod_idx;
    logic [DW-1:0] cons_idx;
    logic [DW-1:0] nxt_prod;
    logic [DW-1:0] nxt_cons;
    logic          base_zero;
    logic          ld_base;
    logic          ld_mask;
    logic          ld_prod;
    logic          ld_cons;
    logic          adv_prod;
    logic          adv_cons;
    logic          cmd_addr_zero;
    addr_sel_e     addr_sel;

    assign cmd_addr_zero = (cmd_addr == '0);

    shm_ring_desc #(.AW(AW), .DW(DW)) u_desc (
        .clk      (clk),
        .rst      (rst),
        .ld_base  (ld_base),
        .base_in  (cmd_addr),
        .ld_mask  (ld_mask),
        .ld_prod  (ld_prod),
        .ld_cons  (ld_cons),
        .ld_val   (mem_rdata),
        .adv_prod (adv_prod),
        .adv_cons (adv_cons),
        .base     (base),
        .mask     (mask),
        .prod_idx (prod_idx),
        .cons_idx (cons_idx),
        .nxt_prod (nxt_prod),
        .nxt_cons (nxt_cons),
        .base_zero(base_zero)
    );

    shm_ring_agen #(.AW(AW), .DW(DW)) u_agen (
        .base    (base),
        .sel     (addr_sel),
        .prod_idx(prod_idx),
        .cons_idx(cons_idx),
        .addr    (mem_addr)
    );

    shm_ring_seq #(.DW(DW)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_ready    (cmd_ready),
        .cmd_op       (cmd_op),
        .cmd_addr_zero(cmd_addr_zero),
        .cmd_data     (cmd_data),
        .base_zero    (base_zero),
        .rsp_valid    (rsp_valid),
        .rsp_flag     (rsp_flag),
        .rsp_err      (rsp_err),
        .rsp_data     (rsp_data),
        .bus_req      (bus_req),
        .bus_grant    (bus_grant),
        .mem_valid    (mem_valid),
        .mem_we       (mem_we),
        .mem_wdata    (mem_wdata),
        .addr_sel     (addr_sel),
        .mem_ready    (mem_ready),
        .mem_rdata    (mem_rdata),
        .cons_idx     (cons_idx),
        .nxt_prod     (nxt_prod),
        .nxt_cons     (nxt_cons),
        .ld_base      (ld_base),
        .ld_mask      (ld_mask),
        .ld_prod      (ld_prod),
        .ld_cons      (ld_cons),
        .adv_prod     (adv_prod),
        .adv_cons     (adv_cons)
    );

endmodule

// File: rtl/shm_ring_port_chk.sv
module shm_ring_port_chk #(
    parameter int unsigned AW = 19
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [2:0]    cmd_op,
    input logic          rsp_valid,
    input logic          bus_req,
    input logic          bus_grant,
    input logic          mem_valid,
    input logic          mem_ready,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          base_zero
);

    // R1: the cycle after a reset edge shows an idle, released block
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!rsp_valid && !bus_req && !mem_valid));

    // R9: memory traffic only inside a granted tenure
    p_access_in_tenure_r9: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (bus_req && bus_grant));

    // R9: an idle block holds no bus request
    p_idle_released_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !bus_req);

    // R10: unconfigured non-init commands answer next cycle without the bus
    p_unconf_fast_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && base_zero && (cmd_op != 3'd0))
        |=> (rsp_valid && !bus_req));

    // R12: a stalled access keeps its command
    p_hold_access_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready)
        |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

    // R13: responses appear only while ready
    p_rsp_when_ready_r13: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> cmd_ready);

    // R13: a response is a single pulse unless a new command was taken
    p_rsp_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !cmd_valid) |=> !rsp_valid);

endmodule

bind shm_ring_port shm_ring_port_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_op   (cmd_op),
    .rsp_valid(rsp_valid),
    .bus_req  (bus_req),
    .bus_grant(bus_grant),
    .mem_valid(mem_valid),
    .mem_ready(mem_ready),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .base_zero(base_zero)
);

// File: tb/shm_ring_port_test.sv
module shm_ring_port_test;

    localparam int unsigned AW = 19;
    localparam int unsigned DW = 8;
    localparam logic [AW-1:0] BASE_A = 19'h40110;

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] wd;
        logic       fl;
        logic       er;
        logic [7:0] rd;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 8'h00, 1'b0, 1'b0, 8'h00},
        '{3'd1, 8'h00, 1'b0, 1'b0, 8'h00},
        '{3'd2, 8'h00, 1'b0, 1'b0, 8'h00},
        '{3'd3, 8'h00, 1'b0, 1'b0, 8'hA0},
        '{3'd3, 8'h00, 1'b0, 1'b0, 8'hA1},
        '{3'd1, 8'h00, 1'b1, 1'b0, 8'h00},
        '{3'd4, 8'h55, 1'b0, 1'b0, 8'h00},
        '{3'd3, 8'h00, 1'b0, 1'b0, 8'h55},
        '{3'd4, 8'h61, 1'b0, 1'b0, 8'h00},
        '{3'd4, 8'h62, 1'b0, 1'b0, 8'h00},
        '{3'd4, 8'h63, 1'b0, 1'b0, 8'h00},
        '{3'd4, 8'h64, 1'b0, 1'b0, 8'h00},
        '{3'd4, 8'h65, 1'b0, 1'b0, 8'h00},
        '{3'd4, 8'h66, 1'b0, 1'b0, 8'h00},
        '{3'd4, 8'h67, 1'b0, 1'b0, 8'h00},
        '{3'd2, 8'h00, 1'b1, 1'b0, 8'h00},
        '{3'd1, 8'h00, 1'b0, 1'b0, 8'h00},
        '{3'd3, 8'h00, 1'b0, 1'b0, 8'h61},
        '{3'd2, 8'h00, 1'b0, 1'b0, 8'h00},
        '{3'd3, 8'h00, 1'b0, 1'b0, 8'h62}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [2:0]    cmd_op = 3'd0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic          rsp_valid;
    logic          rsp_flag;
    logic          rsp_err;
    logic [DW-1:0] rsp_data;
    logic          bus_req;
    logic          bus_grant = 1'b0;
    logic          mem_valid;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ready;
    logic [DW-1:0] mem_rdata;

    always #10 clk = ~clk;

    shm_ring_port #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_flag(rsp_flag), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .bus_req(bus_req), .bus_grant(bus_grant),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    // target memory model (256-byte window), bus controller and monitors
    logic [7:0]    mem [0:255];
    logic [31:0]   cyc = 0;
    logic [31:0]   acc_cnt = 0;
    logic [31:0]   req_rises = 0;
    logic          req_prev = 1'b0;
    logic [AW-1:0] first_addr = '0;
    logic          poke_en = 1'b0;
    logic [7:0]    poke_a = '0;
    logic [7:0]    poke_d = '0;
    logic          clr_cnt = 1'b0;
    logic          stall_en = 1'b0;

    always_comb mem_rdata = mem[mem_addr[7:0]];
    assign mem_ready = mem_valid && !(stall_en && cyc[0]);

    always @(posedge clk) begin
        cyc       <= cyc + 1;
        bus_grant <= rst ? 1'b0 : bus_req;
        req_prev  <= bus_req;
        if (mem_valid && mem_ready) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            if (acc_cnt == 0) first_addr <= mem_addr;
            acc_cnt <= acc_cnt + 1;
        end
        if (bus_req && !req_prev) req_rises <= req_rises + 1;
        if (poke_en) mem[poke_a] <= poke_d;
        if (clr_cnt) begin
            acc_cnt   <= 0;
            req_rises <= 0;
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    logic          r_flag, r_err, r_rdy, r_gnt;
    logic [DW-1:0] r_data;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        poke_en = 1'b1; poke_a = a; poke_d = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic clear_mon();
        clr_cnt = 1'b1;
        @(negedge clk);
        clr_cnt = 1'b0;
    endtask

    // called at a negedge; drives at once so a command can meet a response cycle
    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_rsp(input string tag);
        int n = 0;
        while (!rsp_valid && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (!rsp_valid) begin
            n_chk++; n_bad++;
            $display("FAIL %s response timeout: actual none expected pulse", tag);
        end
        r_flag = rsp_flag; r_err = rsp_err; r_data = rsp_data;
        r_rdy = cmd_ready; r_gnt = bus_grant;
    endtask

    task automatic run(input logic [2:0] op, input logic [AW-1:0] a,
                       input logic [7:0] d, input string tag);
        issue(op, a, d);
        wait_rsp(tag);
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0:    return "R3";
            3'd1:    return "R4";
            3'd2:    return "R5";
            3'd3:    return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        summary();
        $finish;
    end

    initial begin
        logic early;
        logic [31:0] req_snap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1", "cmd_ready", cmd_ready, 1);
        check("R1", "bus_req", bus_req, 0);
        check("R1", "mem_valid", mem_valid, 0);
        check("R1", "rsp_valid", rsp_valid, 0);

        // R10 unconfigured, commands back to back (R13)
        clear_mon();
        run(3'd1, '0, 8'h00, "R10");
        check("R10", "empty flag", r_flag, 1);
        check("R10", "empty err", r_err, 0);
        run(3'd2, '0, 8'h00, "R10");
        check("R10", "full flag", r_flag, 1);
        check("R13", "ready at rsp", r_rdy, 1);
        run(3'd3, '0, 8'h00, "R10");
        check("R10", "get err", r_err, 1);
        run(3'd4, '0, 8'h11, "R10");
        check("R10", "put err", r_err, 1);
        run(3'd0, '0, 8'h00, "R10");
        check("R10", "zero init err", r_err, 0);
        run(3'd1, '0, 8'h00, "R10");
        check("R10", "still unconfigured", r_flag, 1);
        check("R10", "no accesses", acc_cnt, 0);
        check("R10", "no bus request", req_rises, 0);

        // table-driven main sequence, each command issued in the previous response cycle
        poke(8'h0D, 8'h07);
        poke(8'h0E, 8'h02);
        poke(8'h0F, 8'h00);
        for (int i = 0; i < 8; i++) poke(8'h10 + 8'(i), 8'hA0 + 8'(i));
        clear_mon();
        for (int i = 0; i < NV; i++) begin
            run(VEC[i].op, BASE_A, VEC[i].wd, tag_of(VEC[i].op));
            check(tag_of(VEC[i].op), "flag", r_flag, VEC[i].fl);
            check(tag_of(VEC[i].op), "err", r_err, VEC[i].er);
            check(tag_of(VEC[i].op), "data", r_data, VEC[i].rd);
            check("R13", "ready at rsp", r_rdy, 1);
            check("R9", "grant low at rsp", r_gnt, 0);
            if (i == 0) begin
                check("R3", "first init address", first_addr, 19'h4010D);
                check("R3", "init access count", acc_cnt, 3);
            end
        end
        check("R6", "consumer index written", mem[8'h0F], 8'h05);
        check("R7", "producer index wrapped", mem[8'h0E], 8'h02);
        check("R7", "stored byte slot 2", mem[8'h12], 8'h55);
        check("R7", "stored byte after wrap", mem[8'h11], 8'h67);

        // R2 unknown operation code
        clear_mon();
        run(3'd5, BASE_A, 8'h00, "R2");
        check("R2", "code 5 err", r_err, 1);
        check("R2", "code 5 no access", acc_cnt, 0);
        run(3'd7, BASE_A, 8'h00, "R2");
        check("R2", "code 7 err", r_err, 1);

        // R8 take on an empty buffer waits, releasing the bus between polls
        poke(8'h3D, 8'h07);
        poke(8'h3E, 8'h00);
        poke(8'h3F, 8'h00);
        run(3'd0, 19'h40140, 8'h00, "R3");
        clear_mon();
        issue(3'd3, 19'h40140, 8'h00);
        early = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (rsp_valid) early = 1'b1;
        end
        check("R8", "no response while empty", early, 0);
        req_snap = req_rises;
        check("R8", "re-requests seen", req_snap >= 2, 1);
        poke(8'h40, 8'h3C);
        poke(8'h3E, 8'h01);
        wait_rsp("R8");
        check("R8", "byte after wait", r_data, 8'h3C);
        check("R6", "consumer index after wait", mem[8'h3F], 8'h01);

        // R8 store on a full buffer waits
        poke(8'h7D, 8'h03);
        poke(8'h7E, 8'h03);
        poke(8'h7F, 8'h00);
        run(3'd0, 19'h40180, 8'h00, "R3");
        issue(3'd4, 19'h40180, 8'h77);
        early = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (rsp_valid) early = 1'b1;
        end
        check("R8", "no response while full", early, 0);
        poke(8'h7F, 8'h01);
        wait_rsp("R8");
        check("R8", "stored after wait", mem[8'h83], 8'h77);
        check("R7", "producer index wraps at mask 3", mem[8'h7E], 8'h00);

        // R11 address wrap modulo 2^19
        poke(8'hFE, 8'h03);
        poke(8'hFF, 8'h02);
        poke(8'h00, 8'h01);
        poke(8'h02, 8'h9D);
        clear_mon();
        run(3'd0, 19'h00001, 8'h00, "R11");
        check("R11", "mask address wraps", first_addr, 19'h7FFFE);
        check("R3", "init access count", acc_cnt, 3);
        run(3'd3, 19'h00001, 8'h00, "R11");
        check("R11", "take data", r_data, 8'h9D);
        check("R11", "consumer index at address 0", mem[8'h00], 8'h02);

        // R12 withheld mem_ready
        stall_en = 1'b1;
        run(3'd4, 19'h00001, 8'h4E, "R12");
        check("R12", "stored under stall", mem[8'h03], 8'h4E);
        check("R12", "producer index under stall", mem[8'hFF], 8'h03);
        run(3'd3, 19'h00001, 8'h00, "R12");
        check("R12", "take under stall", r_data, 8'h4E);
        stall_en = 1'b0;

        summary();
        $finish;
    end

endmodule